// File: doc/BRIEF.md
# RGB to Interlaced 4:2:2 Byte Stream Formatter

The formatter takes a progressive stream of 24-bit RGB pixels, 8 bits per component, and turns it into the 8-bit multiplexed YCbCr 4:2:2 byte stream that a digital television encoder expects. Each pair of pixels becomes four bytes: two luma samples and one chroma pair. The chroma pair is worked out from the average of the two pixels.

Progressive frames become interlaced fields through line selection. Each frame start flips the field flag. Within a field, only the lines of matching parity pass through, and the other lines produce no output at all. Every line that passes starts with an end-of-active-video timing reference code, followed by a run of blanking fill and then a start-of-active-video code. The active pixel bytes of the line come after that.

The sequencer runs through five named states:
- IDLE waits, and also swallows dropped lines.
- EAV sends the four end-of-active-video bytes.
- FILL sends the blanking bytes.
- SAV sends the four start-of-active-video bytes.
- ACTIVE accepts pixels and emits the converted bytes.

The transitions are:
- Line start moves IDLE or ACTIVE to EAV when the line is kept, and to IDLE when it is dropped.
- EAV moves to FILL after its fourth byte.
- FILL moves to SAV after BLANK_BYTES bytes.
- SAV moves to ACTIVE after its fourth byte.

Top module: `rgb656_fmt`

## Requirements
- R1: Every two accepted pixels of a line produce four strobed bytes, in the order Cb, Y(first pixel), Cr, Y(second pixel), on four consecutive cycles.
- R2: Luma is computed as Y = 16 + ((66R + 129G + 25B + 128) >>> 8), then clamped to the range 16..235.
- R3: Chroma uses the component sums of the pair, Rs, Gs and Bs. Cb = 128 + ((-38Rs - 74Gs + 112Bs + 256) >>> 9) and Cr = 128 + ((112Rs - 94Gs - 18Bs + 256) >>> 9), each clamped to 16..240. As a result, the values 0x00 and 0xFF never occur among active bytes.
- R4: A kept line starts with FF 00 00 XY with H=1 (end of active video). After the fill comes FF 00 00 XY with H=0 (start of active video). XY is laid out from bit 7 down as 1, F, V, H, V^H, F^H, F^V, F^V^H, and V is always 0.
- R5: Between the two codes the block emits BLANK_BYTES fill bytes, alternating 0x80 and 0x10 and starting with 0x80.
- R6: The field flag F starts at 1 out of reset and inverts on each frame start, so the first frame is sent as F=0. A frame start comes together with the first line start, and lines are counted from 1. With F=0 only odd lines are kept, and with F=1 only even lines. A dropped line produces no strobed byte.
- R7: Pixels beyond the first ACTIVE_PIX of a line are ignored and produce no bytes.
- R8: After reset, out_stb is 0 and out_byte is 0x00. Whenever out_stb is 0, out_byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel present on pix_rgb this cycle |
| pix_rgb | input | 24 | Pixel, R in [23:16], G in [15:8], B in [7:0] |
| line_start | input | 1 | One-cycle pulse starting a new input line |
| frame_start | input | 1 | Pulse with the first line_start of a frame |
| out_byte | output | 8 | Output byte stream |
| out_stb | output | 1 | out_byte carries a valid byte |

## Verification
The assertions assume the input interface keeps to a pacing contract:
- pix_valid is never high on two consecutive cycles.
- No pixel arrives before 9 + BLANK_BYTES cycles have passed since line_start.
- A line ends at least five cycles after its last pixel.

Under these rules the four bytes of one pair never overlap the next pair or the codes. The bench holds to the contract by design: it waits fourteen idle cycles after each line start, sends pixels on every other cycle, and allows eight idle cycles at the end of each line. Within these limits it sweeps extreme and hashed colours across several frames, so that both field parities, dropped lines and over-long lines are all exercised.

// File: rtl/rgb656_pkg.sv
package rgb656_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EAV,
        ST_FILL,
        ST_SAV,
        ST_ACTIVE
    } seq_state_t;

    localparam logic [7:0] LUMA_MIN   = 8'd16;
    localparam logic [7:0] LUMA_MAX   = 8'd235;
    localparam logic [7:0] CHROMA_MIN = 8'd16;
    localparam logic [7:0] CHROMA_MAX = 8'd240;
    localparam logic [7:0] FILL_CHR   = 8'h80;
    localparam logic [7:0] FILL_LUM   = 8'h10;
    localparam logic [7:0] CODE_LEAD  = 8'hFF;
    localparam logic [7:0] CODE_ZERO  = 8'h00;

    // Fourth code word: 1 F V H and four protection bits.
    function automatic logic [7:0] trs_word(input logic f, input logic v, input logic h);
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

endpackage

// File: rtl/rgb656_csc.sv
module rgb656_csc
    import rgb656_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_acc,
    input  logic        pix_odd,
    input  logic [23:0] pix_rgb,
    output logic        pair_rdy,
    output logic [7:0]  y0,
    output logic [7:0]  y1,
    output logic [7:0]  cb,
    output logic [7:0]  cr
);

    logic [23:0] first_px;

    function automatic logic [7:0] clamp8(input int v, input logic [7:0] lo, input logic [7:0] hi);
        if (v < int'(lo)) return lo;
        if (v > int'(hi)) return hi;
        return 8'(v);
    endfunction

    function automatic logic [7:0] luma(input logic [23:0] p);
        int s;
        s = 66 * int'(p[23:16]) + 129 * int'(p[15:8]) + 25 * int'(p[7:0]) + 128;
        s = 16 + (s >>> 8);
        return clamp8(s, LUMA_MIN, LUMA_MAX);
    endfunction

    function automatic logic [7:0] chroma(input int kr, input int kg, input int kb,
                                          input int rs, input int gs, input int bs);
        int s;
        s = kr * rs + kg * gs + kb * bs + 256;
        s = 128 + (s >>> 9);
        return clamp8(s, CHROMA_MIN, CHROMA_MAX);
    endfunction

    int sum_r, sum_g, sum_b;
    always_comb begin
        sum_r = int'(first_px[23:16]) + int'(pix_rgb[23:16]);
        sum_g = int'(first_px[15:8])  + int'(pix_rgb[15:8]);
        sum_b = int'(first_px[7:0])   + int'(pix_rgb[7:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_px <= '0;
            pair_rdy <= 1'b0;
            y0       <= LUMA_MIN;
            y1       <= LUMA_MIN;
            cb       <= FILL_CHR;
            cr       <= FILL_CHR;
        end else begin
            pair_rdy <= pix_acc && pix_odd;
            if (pix_acc && !pix_odd) begin
                first_px <= pix_rgb;
            end
            if (pix_acc && pix_odd) begin
                y0 <= luma(first_px);
                y1 <= luma(pix_rgb);
                cb <= chroma(-38, -74, 112, sum_r, sum_g, sum_b);
                cr <= chroma(112, -94, -18, sum_r, sum_g, sum_b);
            end
        end
    end

    a_r2_luma_range: assert property (@(posedge clk) disable iff (!rst_n)
        pair_rdy |-> (y0 >= LUMA_MIN && y0 <= LUMA_MAX && y1 >= LUMA_MIN && y1 <= LUMA_MAX));

    a_r3_chroma_range: assert property (@(posedge clk) disable iff (!rst_n)
        pair_rdy |-> (cb >= CHROMA_MIN && cb <= CHROMA_MAX && cr >= CHROMA_MIN && cr <= CHROMA_MAX));

endmodule

// File: rtl/rgb656_field.sv
module rgb656_field (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic frame_start,
    output logic keep_line,
    output logic f_next
);

    logic field_f;
    logic line_odd;
    logic odd_next;

    always_comb begin
        f_next    = frame_start ? ~field_f : field_f;
        odd_next  = frame_start ? 1'b1 : ~line_odd;
        keep_line = line_start && (odd_next == ~f_next);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_f  <= 1'b1;
            line_odd <= 1'b0;
        end else if (line_start) begin
            field_f  <= f_next;
            line_odd <= odd_next;
        end
    end

    // R6: each frame flips the field flag
    a_r6_field_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && frame_start) |=> (field_f != $past(field_f)));

endmodule

// File: rtl/rgb656_seq.sv
module rgb656_seq
    import rgb656_pkg::*;
#(
    parameter int ACTIVE_PIX  = 8,
    parameter int BLANK_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       keep_line,
    input  logic       f_next,
    input  logic       pix_valid,
    input  logic       pair_rdy,
    input  logic [7:0] y0,
    input  logic [7:0] y1,
    input  logic [7:0] cb,
    input  logic [7:0] cr,
    output logic       pix_acc,
    output logic       pix_odd,
    output logic [7:0] out_byte,
    output logic       out_stb
);

    localparam int CNT_MAX = (BLANK_BYTES > 4) ? BLANK_BYTES : 4;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int PIX_W   = $clog2(ACTIVE_PIX + 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [PIX_W-1:0] pix_cnt;
    logic             f_line;
    logic             emit_on;
    logic [1:0]       emit_ph;

    assign pix_acc = pix_valid && !line_start && (state == ST_ACTIVE) &&
                     (pix_cnt < PIX_W'(ACTIVE_PIX));
    assign pix_odd = pix_cnt[0];

    function automatic logic [7:0] code_byte(input logic [CNT_W-1:0] idx,
                                             input logic f, input logic h);
        if (idx == CNT_W'(0)) return CODE_LEAD;
        if (idx == CNT_W'(3)) return trs_word(f, 1'b0, h);
        return CODE_ZERO;
    endfunction

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            pix_cnt <= '0;
            f_line  <= 1'b0;
        end else if (line_start) begin
            state   <= keep_line ? ST_EAV : ST_IDLE;
            cnt     <= '0;
            pix_cnt <= '0;
            f_line  <= f_next;
        end else begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_EAV: begin
                    if (cnt == CNT_W'(3)) begin
                        state <= ST_FILL;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FILL: begin
                    if (cnt == CNT_W'(BLANK_BYTES - 1)) begin
                        state <= ST_SAV;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SAV: begin
                    if (cnt == CNT_W'(3)) begin
                        state <= ST_ACTIVE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACTIVE: begin
                    if (pix_acc) pix_cnt <= pix_cnt + 1'b1;
                end
            endcase
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= 8'h00;
            out_stb  <= 1'b0;
            emit_on  <= 1'b0;
            emit_ph  <= 2'd0;
        end else begin
            out_byte <= 8'h00;
            out_stb  <= 1'b0;
            if (emit_on) begin
                out_stb <= 1'b1;
                emit_ph <= emit_ph + 1'b1;
                unique case (emit_ph)
                    2'd1:    out_byte <= y0;
                    2'd2:    out_byte <= cr;
                    default: begin
                        out_byte <= y1;
                        emit_on  <= 1'b0;
                    end
                endcase
            end else if (pair_rdy && state == ST_ACTIVE) begin
                out_byte <= cb;
                out_stb  <= 1'b1;
                emit_on  <= 1'b1;
                emit_ph  <= 2'd1;
            end else begin
                unique case (state)
                    ST_EAV: begin
                        out_byte <= code_byte(cnt, f_line, 1'b1);
                        out_stb  <= 1'b1;
                    end
                    ST_FILL: begin
                        out_byte <= cnt[0] ? FILL_LUM : FILL_CHR;
                        out_stb  <= 1'b1;
                    end
                    ST_SAV: begin
                        out_byte <= code_byte(cnt, f_line, 1'b0);
                        out_stb  <= 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    a_r1_no_pair_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        pair_rdy |-> !emit_on);

    a_r4_code_lead: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && out_byte == CODE_LEAD) |=> (out_stb && out_byte == CODE_ZERO));

    a_r7_pix_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pix_cnt <= PIX_W'(ACTIVE_PIX));

    a_r8_quiet_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !out_stb |-> (out_byte == 8'h00));

endmodule

// File: rtl/rgb656_fmt.sv
module rgb656_fmt #(
    parameter int ACTIVE_PIX  = 8,
    parameter int BLANK_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pix_valid,
    input  logic [23:0] pix_rgb,
    input  logic        line_start,
    input  logic        frame_start,
    output logic [7:0]  out_byte,
    output logic        out_stb
);

    logic       keep_line, f_next;
    logic       pix_acc, pix_odd, pair_rdy;
    logic [7:0] y0, y1, cb, cr;

    rgb656_field field_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .frame_start(frame_start),
        .keep_line  (keep_line),
        .f_next     (f_next)
    );

    rgb656_csc csc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_acc (pix_acc),
        .pix_odd (pix_odd),
        .pix_rgb (pix_rgb),
        .pair_rdy(pair_rdy),
        .y0      (y0),
        .y1      (y1),
        .cb      (cb),
        .cr      (cr)
    );

    rgb656_seq #(
        .ACTIVE_PIX (ACTIVE_PIX),
        .BLANK_BYTES(BLANK_BYTES)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_start(line_start),
        .keep_line (keep_line),
        .f_next    (f_next),
        .pix_valid (pix_valid),
        .pair_rdy  (pair_rdy),
        .y0        (y0),
        .y1        (y1),
        .cb        (cb),
        .cr        (cr),
        .pix_acc   (pix_acc),
        .pix_odd   (pix_odd),
        .out_byte  (out_byte),
        .out_stb   (out_stb)
    );

    // R1: input pacing contract, at most one pixel every other cycle
    a_r1_input_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);

endmodule

// File: tb/rgb656_fmt_tb_top.sv
module rgb656_fmt_tb_top;

    localparam int AP  = 8;
    localparam int BB  = 4;
    localparam int GAP = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pix_valid;
    logic [23:0] pix_rgb;
    logic        line_start;
    logic        frame_start;
    logic [7:0]  out_byte;
    logic        out_stb;

    always #5 clk = ~clk;

    rgb656_fmt #(.ACTIVE_PIX(AP), .BLANK_BYTES(BB)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_rgb    (pix_rgb),
        .line_start (line_start),
        .frame_start(frame_start),
        .out_byte   (out_byte),
        .out_stb    (out_stb)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] got[$];
    logic [7:0] exp_q[$];
    string      tag_q[$];
    bit m_field = 1'b1;
    bit m_odd   = 1'b0;

    always @(negedge clk) if (rst_n === 1'b1 && out_stb === 1'b1) got.push_back(out_byte);

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic int clampi(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic logic [7:0] ref_y(input logic [23:0] p);
        int s = 66 * int'(p[23:16]) + 129 * int'(p[15:8]) + 25 * int'(p[7:0]) + 128;
        return 8'(clampi(16 + (s >>> 8), 16, 235));
    endfunction

    function automatic logic [7:0] ref_c(input bit is_cr, input logic [23:0] a, input logic [23:0] b);
        int rs = int'(a[23:16]) + int'(b[23:16]);
        int gs = int'(a[15:8]) + int'(b[15:8]);
        int bs = int'(a[7:0]) + int'(b[7:0]);
        int s  = is_cr ? (112 * rs - 94 * gs - 18 * bs + 256) : (-38 * rs - 74 * gs + 112 * bs + 256);
        return 8'(clampi(128 + (s >>> 9), 16, 240));
    endfunction

    function automatic logic [7:0] ref_xy(input bit f, input bit h);
        bit v = 1'b0;
        return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [23:0] pat(input int seed, input int k);
        case (seed)
            0: return 24'h000000;
            1: return 24'hFFFFFF;
            2: return (k % 2 == 0) ? 24'hFF0000 : 24'h0000FF;
            3: return (k % 2 == 0) ? 24'h00FF00 : 24'hFFFFFF;
            default: return {8'(seed * 37 + k * 73), 8'(seed * 91 + k * 29), 8'(seed * 53 + k * 151)};
        endcase
    endfunction

    task automatic push(input logic [7:0] b, input string t);
        exp_q.push_back(b);
        tag_q.push_back(t);
    endtask

    task automatic send_line(input bit fs, input int npix, input int seed, input string extra);
        bit keep;
        int nuse;
        if (fs) m_field = ~m_field;
        m_odd = fs ? 1'b1 : ~m_odd;
        keep = (m_odd == ~m_field);
        nuse = (npix > AP) ? AP : npix;
        if (keep) begin
            push(8'hFF, "R4 eav"); push(8'h00, "R4 eav"); push(8'h00, "R4 eav");
            push(ref_xy(m_field, 1'b1), "R4 R6 eav xy");
            for (int i = 0; i < BB; i++) push((i % 2 == 0) ? 8'h80 : 8'h10, "R5 fill");
            push(8'hFF, "R4 sav"); push(8'h00, "R4 sav"); push(8'h00, "R4 sav");
            push(ref_xy(m_field, 1'b0), "R4 R6 sav xy");
            for (int k = 0; k + 1 < nuse; k += 2) begin
                push(ref_c(1'b0, pat(seed, k), pat(seed, k + 1)), {"R1 R3 cb ", extra});
                push(ref_y(pat(seed, k)), {"R1 R2 y0 ", extra});
                push(ref_c(1'b1, pat(seed, k), pat(seed, k + 1)), {"R1 R3 cr ", extra});
                push(ref_y(pat(seed, k + 1)), {"R1 R2 y1 ", extra});
            end
        end
        @(negedge clk);
        line_start = 1'b1;
        frame_start = fs;
        @(negedge clk);
        line_start = 1'b0;
        frame_start = 1'b0;
        repeat (GAP) @(negedge clk);
        for (int k = 0; k < npix; k++) begin
            pix_valid = 1'b1;
            pix_rgb = pat(seed, k);
            @(negedge clk);
            pix_valid = 1'b0;
            @(negedge clk);
        end
        repeat (8) @(negedge clk);
        check(got.size() == exp_q.size(), keep ? {"R6 R7 byte count ", extra} : "R6 dropped line silent",
              got.size(), exp_q.size());
        for (int i = 0; i < got.size() && i < exp_q.size(); i++) begin
            check(got[i] == exp_q[i], tag_q[i], got[i], exp_q[i]);
            if (tag_q[i][0] == "R" && tag_q[i][1] == "1")
                check(got[i] != 8'h00 && got[i] != 8'hFF, "R3 no 00/FF in active", got[i], 8'h80);
        end
        got.delete();
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        pix_valid = 1'b0;
        pix_rgb = '0;
        line_start = 1'b0;
        frame_start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check(out_stb == 1'b0, "R8 reset strobe", out_stb, 0);
        check(out_byte == 8'h00, "R8 reset byte", out_byte, 0);
        check(got.size() == 0, "R8 no bytes before line", got.size(), 0);

        for (int fr = 0; fr < 3; fr++) begin
            for (int ln = 0; ln < 6; ln++) begin
                int seed = fr * 6 + ln;
                int n = (ln == 4) ? AP + 2 : AP;
                send_line(ln == 0, n, seed, (ln == 4) ? "R7 extra pixels" : "");
            end
        end
        for (int sd = 20; sd < 40; sd++) send_line(sd == 20, AP, sd, "sweep");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule